// File: doc/BRIEF.md
# Peripheral DMA Request Handshake Controller

This block runs the request side of a DMA handshake between a peripheral's endpoint buffer and an external DMA controller that moves data to or from shared memory. Software writes a small configuration word that sets a run bit, a transfer direction, an automatic re-arm bit and a burst length code. While running, the block raises its request line only when the buffer can take part in a transfer in the chosen direction. A read toward memory needs a full buffer. A write from memory needs an empty buffer.

The external controller answers each transfer cycle with an active-low acknowledge and an active-low read or write strobe. The block counts acknowledged cycles and withdraws the request when a burst is done. In single-cycle mode it withdraws the request on the acknowledge itself. It raises the request again for the next burst once the buffer is ready again. An active-low end-of-transfer input, qualified by an acknowledged cycle, ends the operation. Software can also end it at any time by writing the run bit to zero.

Top module: `dmareq_ctrl`

## Requirements
- R1: During and after reset, `dreq`, `run_en` and `xfer_pulse` are 0.
- R2: Configuration word layout is bit 0 run, bit 1 direction (1 = memory to peripheral, 0 = peripheral to memory), bit 2 re-arm, bits 4:3 burst code. `run_en` shows the run bit from the clock after the write.
- R3: While running and idle, `dreq` rises one clock after the buffer is ready. Ready means `buf_full` for direction 0 and `buf_empty` for direction 1. `dreq` stays 0 while the buffer is not ready.
- R4: A transfer cycle is the rising edge of `rd_n` or `wr_n` seen while `ack_n` is 0 and the block is running. Each such cycle gives a one-clock `xfer_pulse` one clock later. A strobe edge while `ack_n` is 1 gives no pulse and does not advance the burst count.
- R5: With burst code 00 (single cycle), `dreq` falls on the clock after `ack_n` is first seen low.
- R6: With burst codes 01, 10 and 11 (4, 8 and 16 cycles), `dreq` stays high until the last cycle of the burst and falls on the clock that counts it.
- R7: After `dreq` falls at the end of a burst, it stays low for at least one clock. It also stays low until the buffer is ready and `ack_n` is 1, and it rises one clock after both hold.
- R8: An end-of-transfer input (`eot_n` = 0) on a counted cycle with re-arm 0 clears `run_en` and drops `dreq` on that clock, and `dreq` stays low afterwards.
- R9: The same end-of-transfer condition with re-arm 1 keeps `run_en` at 1, drops `dreq` for one gap, and starts a fresh burst count.
- R10: Writing the run bit as 0 clears `run_en` and `dreq` on the next clock.
- R11: Any configuration write discards a partly counted burst, so the next burst is counted in full from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Configuration word (run, direction, re-arm, burst code) |
| buf_full | input | 1 | Endpoint buffer holds a full packet |
| buf_empty | input | 1 | Endpoint buffer is empty |
| ack_n | input | 1 | Active-low acknowledge from the DMA controller |
| eot_n | input | 1 | Active-low end of transfer |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| dreq | output | 1 | DMA request |
| run_en | output | 1 | Current run bit |
| xfer_pulse | output | 1 | One-clock pulse per counted transfer cycle |

## Verification
The bench sweeps both directions against all four burst codes. In each case it runs two full bursts, so the point where the request drops shows whether the length decoder and the counter agree for every code, and whether direction picks the right buffer flag. Focused sequences then set each pattern against its nearest neighbour. A strobe without acknowledge is set against a counted one. A buffer that is not ready is set against one that is ready after a burst. A configuration rewrite in mid-burst is set against an uninterrupted burst. End-of-transfer with re-arm off is set against end-of-transfer with re-arm on, which tells a stop apart from a restart with a fresh count.

// File: rtl/dmareq_pkg.sv
package dmareq_pkg;

  localparam int MAX_BURST = 16;
  localparam int CNT_W     = $clog2(MAX_BURST);
  localparam int CFG_W     = 5;

  typedef struct packed {
    logic [1:0] burst;
    logic       rearm;
    logic       dir;
    logic       run;
  } cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_GAP  = 2'd2
  } seq_st_e;

  function automatic logic [CNT_W-1:0] last_index(input logic [1:0] code);
    int len;
    len = (code == 2'b00) ? 1 : (1 << (int'(code) + 1));
    return CNT_W'(len - 1);
  endfunction

endpackage

// File: rtl/dmareq_cfg.sv
module dmareq_cfg
  import dmareq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             stop_req,
  output cfg_t             cfg
);

  cfg_t cfg_q, cfg_d;
  logic cfg_en;

  always_comb begin
    cfg_d  = cfg_q;
    cfg_en = 1'b0;
    if (cfg_we) begin
      cfg_d  = cfg_t'(cfg_wdata);
      cfg_en = 1'b1;
    end else if (stop_req) begin
      cfg_d.run = 1'b0;
      cfg_en    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;

  // R8
  stop_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !cfg_we) |=> !cfg_q.run);

  // R2
  write_loads_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_q.run == $past(cfg_wdata[0])));

endmodule

// File: rtl/dmareq_edge.sv
module dmareq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ack_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic cyc_valid,
  output logic xfer_pulse
);

  logic rd_q, wr_q, pulse_q;
  logic strobe_rise;

  assign strobe_rise = (rd_n && !rd_q) || (wr_n && !wr_q);
  assign cyc_valid   = run && !ack_n && strobe_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= 1'b1;
      wr_q    <= 1'b1;
      pulse_q <= 1'b0;
    end else begin
      rd_q    <= rd_n;
      wr_q    <= wr_n;
      pulse_q <= cyc_valid;
    end
  end

  assign xfer_pulse = pulse_q;

  // R4
  pulse_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_pulse |-> $past(!ack_n && run));

endmodule

// File: rtl/dmareq_seq.sv
module dmareq_seq
  import dmareq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cfg_t cfg,
  input  logic cfg_we,
  input  logic buf_full,
  input  logic buf_empty,
  input  logic ack_n,
  input  logic eot_n,
  input  logic cyc_valid,
  output logic stop_req,
  output logic dreq
);

  seq_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, last;
  logic             ready, eot_hit, burst_done, single;

  assign ready    = cfg.dir ? buf_empty : buf_full;
  assign last     = last_index(cfg.burst);
  assign single   = (cfg.burst == 2'b00);
  assign eot_hit  = cyc_valid && !eot_n;
  assign stop_req = eot_hit && !cfg.rearm;

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    burst_done = 1'b0;
    if (cfg_we || !cfg.run) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
    end else if (eot_hit) begin
      st_d  = cfg.rearm ? ST_GAP : ST_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (ready) st_d = ST_REQ;
        ST_REQ: begin
          if (single) begin
            if (!ack_n) begin
              st_d       = ST_GAP;
              burst_done = 1'b1;
            end
          end else if (cyc_valid) begin
            if (cnt_q == last) begin
              st_d       = ST_GAP;
              cnt_d      = '0;
              burst_done = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_GAP: if (ready && ack_n) st_d = ST_REQ;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign dreq = (st_q == ST_REQ);

  // R3
  rise_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dreq) |-> $past(ready && cfg.run));

  // R10
  idle_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.run |-> !dreq);

  // R7
  gap_after_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dreq && burst_done) |=> !dreq);

  // R6
  count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last);

endmodule

// File: rtl/dmareq_ctrl.sv
module dmareq_ctrl
  import dmareq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             buf_full,
  input  logic             buf_empty,
  input  logic             ack_n,
  input  logic             eot_n,
  input  logic             rd_n,
  input  logic             wr_n,
  output logic             dreq,
  output logic             run_en,
  output logic             xfer_pulse
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  cfg_t       cfg;
  logic       cyc_valid, stop_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dmareq_cfg i_cfg (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .stop_req  (stop_req),
    .cfg       (cfg)
  );

  dmareq_edge i_edge (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .run        (cfg.run),
    .ack_n      (ack_n),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .cyc_valid  (cyc_valid),
    .xfer_pulse (xfer_pulse)
  );

  dmareq_seq i_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cfg       (cfg),
    .cfg_we    (cfg_we),
    .buf_full  (buf_full),
    .buf_empty (buf_empty),
    .ack_n     (ack_n),
    .eot_n     (eot_n),
    .cyc_valid (cyc_valid),
    .stop_req  (stop_req),
    .dreq      (dreq)
  );

  assign run_en = cfg.run;

endmodule

// File: tb/test_dmareq_ctrl.sv
module test_dmareq_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [4:0] cfg_wdata;
  logic       buf_full, buf_empty, ack_n, eot_n, rd_n, wr_n;
  logic       dreq, run_en, xfer_pulse;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;
  bit  dir_s  = 0;

  always #4 clk = ~clk;

  dmareq_ctrl i_dmareq_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .buf_full(buf_full), .buf_empty(buf_empty), .ack_n(ack_n), .eot_n(eot_n),
    .rd_n(rd_n), .wr_n(wr_n), .dreq(dreq), .run_en(run_en), .xfer_pulse(xfer_pulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [1:0] code, input bit rearm, input bit dir, input bit run);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = {code, rearm, dir, run};
    dir_s     = dir;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  // one strobe cycle: exp_b = dreq during the strobe, exp_c = dreq after counting
  task automatic xfer(input bit use_ack, input bit eot, input int exp_b,
                      input int exp_c, input int exp_pulse, input string req);
    @(negedge clk);
    ack_n = !use_ack;
    eot_n = !eot;
    if (dir_s) wr_n = 1'b0; else rd_n = 1'b0;
    @(negedge clk);
    chk(req, dreq, exp_b);
    rd_n = 1'b1;
    wr_n = 1'b1;
    @(negedge clk);
    chk(req, dreq, exp_c);
    chk(req, xfer_pulse, exp_pulse);
    ack_n = 1'b1;
    eot_n = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    buf_full = 1'b0; buf_empty = 1'b0;
    ack_n = 1'b1; eot_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", dreq, 0); chk("R1", run_en, 0); chk("R1", xfer_pulse, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", dreq, 0); chk("R1", run_en, 0);

    // sweep over direction and burst code
    for (int d = 0; d < 2; d++) begin
      for (int c = 0; c < 4; c++) begin
        int len;
        len       = (c == 0) ? 1 : (1 << (c + 1));
        buf_full  = (d == 0);
        buf_empty = (d == 1);
        wr_cfg(2'(c), 1'b0, d[0], 1'b1);
        chk("R2", run_en, 1);
        chk("R3", dreq, 0);
        @(negedge clk);
        chk("R3", dreq, 1);
        for (int b = 0; b < 2; b++) begin
          for (int i = 0; i < len; i++) begin
            bit last;
            last = (i == len - 1);
            if (c == 0) xfer(1, 0, 0, 0, 1, "R5");
            else        xfer(1, 0, 1, last ? 0 : 1, 1, "R6");
          end
          @(negedge clk);
          chk("R7", dreq, 1);
        end
        wr_cfg(2'(c), 1'b0, d[0], 1'b0);
        chk("R10", run_en, 0);
        chk("R10", dreq, 0);
      end
    end

    // R3: wrong flag for the direction keeps the request low
    buf_full = 1'b0; buf_empty = 1'b1;
    wr_cfg(2'b01, 1'b0, 1'b0, 1'b1);
    repeat (4) begin
      @(negedge clk);
      chk("R3", dreq, 0);
    end
    buf_full = 1'b1;
    @(negedge clk);
    chk("R3", dreq, 1);

    // R4: strobe without acknowledge is not counted
    xfer(0, 0, 1, 1, 0, "R4");
    xfer(1, 0, 1, 1, 1, "R4");
    xfer(1, 0, 1, 1, 1, "R4");
    xfer(1, 0, 1, 1, 1, "R4");
    xfer(1, 0, 1, 0, 1, "R4");

    // R7: re-raise waits for a ready buffer
    buf_full = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R7", dreq, 0);
    end
    buf_full = 1'b1;
    @(negedge clk);
    chk("R7", dreq, 1);

    // R11: rewrite in mid-burst restarts the count
    xfer(1, 0, 1, 1, 1, "R11");
    xfer(1, 0, 1, 1, 1, "R11");
    wr_cfg(2'b01, 1'b0, 1'b0, 1'b1);
    chk("R11", dreq, 0);
    @(negedge clk);
    chk("R11", dreq, 1);
    for (int i = 0; i < 4; i++) xfer(1, 0, 1, (i == 3) ? 0 : 1, 1, "R11");
    @(negedge clk);
    chk("R11", dreq, 1);

    // R8: end of transfer without re-arm stops
    xfer(1, 0, 1, 1, 1, "R8");
    xfer(1, 1, 1, 0, 1, "R8");
    chk("R8", run_en, 0);
    repeat (2) begin
      @(negedge clk);
      chk("R8", dreq, 0);
    end

    // R9: end of transfer with re-arm restarts with a fresh count
    wr_cfg(2'b01, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    chk("R9", dreq, 1);
    xfer(1, 0, 1, 1, 1, "R9");
    xfer(1, 0, 1, 1, 1, "R9");
    xfer(1, 1, 1, 0, 1, "R9");
    chk("R9", run_en, 1);
    @(negedge clk);
    chk("R9", dreq, 1);
    for (int i = 0; i < 4; i++) xfer(1, 0, 1, (i == 3) ? 0 : 1, 1, "R9");

    // R10: abort while requesting
    @(negedge clk);
    chk("R10", dreq, 1);
    wr_cfg(2'b01, 1'b1, 1'b0, 1'b0);
    chk("R10", run_en, 0);
    chk("R10", dreq, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule